// File: doc/BRIEF.md
# Clock Gear and PLL Source Selector

This block produces the core clock enable of a chip from two timing sources: a crystal oscillator and the output of an on-chip frequency multiplier (PLL). All logic runs in one fast sampling domain. Each source is presented to the block as a one-cycle strobe that marks its rising edges. A selector picks one of the two sources. A power-of-two gear divider then issues one `core_tick` strobe for every 1, 2, 4 or 8 strobes of the chosen source. Software runs the core slowly to save power by raising the gear.

After reset the block runs from the oscillator, with the multiplier halted and the gear at divide-by-1. Software enables the multiplier and picks ×6 or ×8. A settling timer then counts oscillator strobes and raises a readable lock flag once a full binary count has elapsed. Software polls the flag, and only then may it move the source to the multiplier. A request made before lock is dropped. Turning the multiplier off clears the lock, restarts the timer and returns the clock to the oscillator at once.

The divider applies new gear and source settings only on a divided-clock boundary. This means no output period is shorter than the shorter of the old and new periods.

Top module: `clkgear_ctrl`

## Requirements
- R1: `core_tick` is high for one cycle after every N-th strobe of the active source, where N is 1, 2, 4 or 8 for gear codes 0, 1, 2 and 3; gear codes 4 to 7 also give 8.
- R2: After reset, the gear code is 0, the source is the oscillator, and the multiplier enable, the ×8 setting and the lock flag are all 0.
- R3: The control register is at address 0. It holds bit 0 (multiplier enable), bit 1 (1 = ×8, 0 = ×6), bit 4 (source select, 1 = multiplier) and bit 7 (lock flag, read-only). The gear register is at address 1, with the code in bits 2:0. Addresses 2 and 3 and all other bits read 0, and writes to them have no effect. Reads are combinational from `reg_addr`.
- R4: `pll_run` and `pll_x8` follow the stored enable and ×8 bits.
- R5: With the enable set, the lock flag rises on the 2^LOCK_BITS-th oscillator strobe after the enabling write, and not before.
- R6: Writing source select 1 while the lock flag reads 1 moves the clock to the multiplier strobes.
- R7: Writing source select 1 while the lock flag is 0 is ignored, and the bit reads back 0.
- R8: Writing enable 0 clears the lock flag and the source select, and returns the output to the oscillator. A later enable restarts the lock count from zero.
- R9: Gear and source changes take effect only on an output boundary. No output interval is shorter than the smaller of the old and new intervals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all logic |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | One-cycle strobe per oscillator edge |
| pll_tick | input | 1 | One-cycle strobe per multiplier edge |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| pll_run | output | 1 | Enable to the multiplier |
| pll_x8 | output | 1 | Multiplier ratio: 1 = ×8, 0 = ×6 |
| core_tick | output | 1 | Divided core clock strobe |

## Verification
The hardest state to reach is the switch of the source from the oscillator to the multiplier. It needs a full 4096-strobe lock interval to elapse first. Before that, a select request made without lock must be seen to be dropped. The stimulus counts oscillator strobes on the bench side and reads the lock flag one strobe before and one strobe after the expected count. It then requests the switch at divide-by-8, so the transition interval can be checked against the shorter period. Re-enabling after a disable, and reading the flag after a short count, shows that the timer restarts.

// File: rtl/clkgear_pkg.sv
// Package: shared register addresses, bit positions and the source type.
// Assumes a 2-bit address space and fixed gear ratios of 1, 2, 4 and 8.
package clkgear_pkg;
    localparam int ADDR_CTRL = 0;
    localparam int ADDR_GEAR = 1;
    localparam int BIT_EN    = 0;
    localparam int BIT_MULT  = 1;
    localparam int BIT_SRC   = 4;
    localparam int BIT_LOCK  = 7;
    localparam int MAX_SHIFT = 3;

    typedef enum logic {
        SRC_OSC = 1'b0,
        SRC_PLL = 1'b1
    } clk_src_e;
endpackage

// File: rtl/clkgear_lock.sv
// Lock timer: counts oscillator strobes while the multiplier is enabled
// and raises the lock flag after 2^LOCK_BITS of them.
// Assumes: the enable comes from a register; clearing it restarts the count.
module clkgear_lock #(
    parameter int LOCK_BITS = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic osc_tick,
    output logic locked
);
    localparam logic [LOCK_BITS-1:0] CNT_MAX = '1;

    logic [LOCK_BITS-1:0] cnt;

    // Count oscillator strobes until the final count sets the flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt    <= '0;
            locked <= 1'b0;
        end else if (osc_tick && !locked) begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_MAX) begin
                locked <= 1'b1;
            end
        end
    end

    a_r5_lock_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(osc_tick) && $past(en)));

    a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !locked);
endmodule

// File: rtl/clkgear_regs.sv
// Register file: holds the enable, ratio, source request and gear code,
// and returns read data combinationally.
// Assumes: single-cycle writes; a source request needs the lock flag.
module clkgear_regs
    import clkgear_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2,
    parameter int GEAR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              lock_i,
    output logic [DATA_W-1:0] rdata,
    output logic              pll_en_q,
    output logic              mult_q,
    output logic              src_req_q,
    output logic [GEAR_W-1:0] gear_q
);
    logic wr_ctrl;
    logic wr_gear;

    assign wr_ctrl = we && (addr == ADDR_W'(ADDR_CTRL));
    assign wr_gear = we && (addr == ADDR_W'(ADDR_GEAR));

    // Store register fields; a source request without lock is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pll_en_q  <= 1'b0;
            mult_q    <= 1'b0;
            src_req_q <= 1'b0;
            gear_q    <= '0;
        end else if (wr_ctrl) begin
            pll_en_q  <= wdata[BIT_EN];
            mult_q    <= wdata[BIT_MULT];
            src_req_q <= wdata[BIT_SRC] && wdata[BIT_EN] && lock_i;
        end else if (wr_gear) begin
            gear_q <= wdata[GEAR_W-1:0];
        end
    end

    // Assemble read data; unused bits and addresses read zero.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_CTRL)) begin
            rdata[BIT_EN]   = pll_en_q;
            rdata[BIT_MULT] = mult_q;
            rdata[BIT_SRC]  = src_req_q;
            rdata[BIT_LOCK] = lock_i;
        end else if (addr == ADDR_W'(ADDR_GEAR)) begin
            rdata[GEAR_W-1:0] = gear_q;
        end
    end

    a_r7_src_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        src_req_q |-> lock_i);

    a_r2_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!pll_en_q && !mult_q && !src_req_q && gear_q == '0));
endmodule

// File: rtl/clkgear_div.sv
// Gear divider: issues one core strobe per N active-source strobes and
// takes new gear and source settings only on a core strobe.
// Assumes: the source strobes are one cycle wide; a stopped multiplier
// forces an immediate return to the oscillator.
module clkgear_div
    import clkgear_pkg::*;
#(
    parameter int GEAR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              pll_tick,
    input  logic              pll_on,
    input  logic              src_req,
    input  logic [GEAR_W-1:0] gear_req,
    output logic              core_tick
);
    localparam int CNT_W = MAX_SHIFT;

    clk_src_e          src_act;
    logic [GEAR_W-1:0] gear_act;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  last_c;
    logic              sel_tick;

    assign sel_tick = (src_act == SRC_PLL) ? pll_tick : osc_tick;

    // Translate the active gear code into the final count value.
    always_comb begin
        if (gear_act >= GEAR_W'(MAX_SHIFT)) begin
            last_c = '1;
        end else begin
            last_c = CNT_W'((1 << gear_act) - 1);
        end
    end

    // Count source strobes; on wrap emit a strobe and load new settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            gear_act  <= '0;
            src_act   <= SRC_OSC;
            core_tick <= 1'b0;
        end else if (src_act == SRC_PLL && !pll_on) begin
            cnt       <= '0;
            src_act   <= SRC_OSC;
            core_tick <= 1'b0;
        end else if (sel_tick) begin
            if (cnt == last_c) begin
                cnt       <= '0;
                core_tick <= 1'b1;
                gear_act  <= gear_req;
                src_act   <= (src_req && pll_on) ? SRC_PLL : SRC_OSC;
            end else begin
                cnt       <= cnt + 1'b1;
                core_tick <= 1'b0;
            end
        end else begin
            core_tick <= 1'b0;
        end
    end

    a_r9_gear_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gear_act) |-> core_tick);

    a_r8_force_osc: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_on |=> (src_act == SRC_OSC));

    a_r1_tick_from_source: assert property (@(posedge clk) disable iff (!rst_n)
        core_tick |-> ($past(src_act) == SRC_PLL ? $past(pll_tick) : $past(osc_tick)));
endmodule

// File: rtl/clkgear_ctrl.sv
// Top level: clock gear and multiplier source controller.
// Assumes both timing sources arrive as strobes in the clk domain.
module clkgear_ctrl #(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 2,
    parameter int GEAR_W    = 3,
    parameter int LOCK_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              pll_tick,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              pll_run,
    output logic              pll_x8,
    output logic              core_tick
);
    logic              locked;
    logic              src_req;
    logic [GEAR_W-1:0] gear_req;

    clkgear_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .GEAR_W(GEAR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .lock_i(locked), .rdata(reg_rdata),
        .pll_en_q(pll_run), .mult_q(pll_x8), .src_req_q(src_req),
        .gear_q(gear_req)
    );

    clkgear_lock #(.LOCK_BITS(LOCK_BITS)) u_lock (
        .clk(clk), .rst_n(rst_n), .en(pll_run), .osc_tick(osc_tick),
        .locked(locked)
    );

    clkgear_div #(.GEAR_W(GEAR_W)) u_div (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .pll_tick(pll_tick),
        .pll_on(pll_run), .src_req(src_req), .gear_req(gear_req),
        .core_tick(core_tick)
    );
endmodule

// File: tb/clkgear_ctrl_tb.sv
// Scoreboard bench: the driver queues expected core intervals, the monitor
// measures intervals between core strobes and compares them.
module clkgear_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic       pll_tick = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       pll_run;
    logic       pll_x8;
    logic       core_tick;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int last_tick = -1;
    int min_gap = 0;
    int osc_seen = 0;
    bit count_en = 1'b0;
    int ph = 0;
    int    exp_q[$];
    string tag_q[$];

    clkgear_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .pll_tick(pll_tick),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pll_run(pll_run), .pll_x8(pll_x8),
        .core_tick(core_tick)
    );

    always #10 clk = ~clk;

    // Source strobes: oscillator every 4 cycles, multiplier every cycle while run.
    always @(negedge clk) begin
        ph       <= (ph + 1) % 4;
        osc_tick <= (ph == 3);
        pll_tick <= pll_run;
    end

    // Bench-side oscillator strobe count after an enabling write.
    always @(posedge clk) if (count_en && osc_tick) osc_seen++;

    task automatic check_eq(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: measures intervals and pops expected values.
    always @(negedge clk) begin
        cyc++;
        if (core_tick) begin
            if (last_tick >= 0) begin
                if (min_gap > 0) check_eq(int'((cyc - last_tick) >= min_gap), 1, "R9 min interval");
                if (exp_q.size() > 0) check_eq(cyc - last_tick, exp_q.pop_front(), tag_q.pop_front());
            end
            last_tick = cyc;
        end
    end

    task automatic reg_wr(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input int a, output int d);
        @(negedge clk);
        reg_addr = 2'(a);
        #1 d = int'(reg_rdata);
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) begin
            do @(negedge clk); while (!core_tick);
        end
    endtask

    task automatic expect_periods(input int p, input int k, input string tag);
        do @(negedge clk); while (!core_tick);
        #1;
        for (int i = 0; i < k; i++) begin
            exp_q.push_back(p);
            tag_q.push_back(tag);
        end
        wait (exp_q.size() == 0);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R2 reset state
        reg_rd(0, v); check_eq(v, 0, "R2 ctrl after reset");
        reg_rd(1, v); check_eq(v, 0, "R2 gear after reset");
        check_eq(int'(pll_run), 0, "R4 run after reset");
        check_eq(int'(pll_x8), 0, "R4 x8 after reset");
        // R1 gear ratios on the oscillator (strobe every 4 cycles)
        expect_periods(4, 3, "R1 osc div1");
        reg_wr(1, 1); settle(3); expect_periods(8, 3, "R1 osc div2");
        reg_wr(1, 2); settle(3); expect_periods(16, 2, "R1 osc div4");
        reg_wr(1, 3); settle(3); expect_periods(32, 2, "R1 osc div8");
        reg_wr(1, 7); settle(2); expect_periods(32, 2, "R1 code7 div8");
        reg_rd(1, v); check_eq(v, 7, "R3 gear readback");
        // R9: from 32 down to 4, no interval below 4
        min_gap = 4;
        reg_wr(1, 0); settle(3); expect_periods(4, 2, "R9 new gear");
        min_gap = 0;
        // R7: select before lock is dropped
        reg_wr(0, 8'h13);
        osc_seen = 0; count_en = 1'b1;
        reg_rd(0, v); check_eq(v, 8'h03, "R7 select ignored");
        check_eq(int'(pll_run), 1, "R4 run follows");
        check_eq(int'(pll_x8), 1, "R4 x8 follows");
        expect_periods(4, 2, "R7 still oscillator");
        // R5 lock timing
        wait (osc_seen == 4095);
        reg_rd(0, v); check_eq((v >> 7) & 1, 0, "R5 lock one strobe early");
        wait (osc_seen == 4096);
        reg_rd(0, v); check_eq(v, 8'h83, "R5 lock at full count");
        count_en = 1'b0;
        // R6 switch to multiplier at div8, transition no shorter than 8
        reg_wr(1, 3); settle(3);
        min_gap = 8;
        reg_wr(0, 8'h13);
        reg_rd(0, v); check_eq(v, 8'h93, "R6 select accepted");
        settle(3); expect_periods(8, 3, "R6 multiplier div8");
        min_gap = 0;
        reg_wr(1, 0); settle(3); expect_periods(1, 4, "R6 multiplier div1");
        // R8 disable
        reg_wr(0, 8'h00);
        reg_rd(0, v); check_eq(v, 0, "R8 lock and select cleared");
        settle(3); expect_periods(4, 2, "R8 back to oscillator");
        reg_wr(0, 8'h01);
        osc_seen = 0; count_en = 1'b1;
        wait (osc_seen == 100);
        reg_rd(0, v); check_eq(v, 8'h01, "R8 count restarted");
        reg_wr(0, 8'h11);
        reg_rd(0, v); check_eq(v, 8'h01, "R7 select ignored again");
        // R3 reserved addresses and bits
        reg_wr(2, 8'hFF);
        reg_rd(2, v); check_eq(v, 0, "R3 addr2 reads zero");
        reg_rd(3, v); check_eq(v, 0, "R3 addr3 reads zero");
        reg_rd(1, v); check_eq(v, 0, "R3 gear untouched");
        reg_rd(0, v); check_eq(v, 8'h01, "R3 ctrl untouched");
        reg_wr(1, 8'hFA);
        reg_rd(1, v); check_eq(v, 2, "R3 gear bits only");
        reg_wr(0, 8'hEF);
        reg_rd(0, v); check_eq(v, 8'h03, "R3 ctrl reserved bits");
        summary();
    end
endmodule